// File: doc/BRIEF.md
# AUX Side-Channel Request Frame Sequencer

This block turns register writes into request frames for an auxiliary side channel. Software first sets a device-address register and pushes any payload bytes into a write-data FIFO. It then writes a command word. That command write, taken while the sequencer is idle, launches a frame. The frame goes out one symbol at a time to a downstream line encoder over a valid/ready symbol stream. The encoder adds the line coding, the preamble and the reply handling. This block only decides which symbols go out and in what order.

Each symbol has a kind tag and a byte. Every frame opens with a start symbol and closes with a stop symbol. Between them come the command byte, the device address, and then, depending on the command, a length byte and payload bytes. One bit of the command word asks for a short address-only frame. That form is used to set up or close a bus session and to poll the status of an earlier write. Read bursts carry a length but no payload. Write bursts drain their payload from the FIFO.

Back-pressure rules: the sequencer raises `sym_valid` and holds `sym_kind` and `sym_byte` unchanged until `sym_ready` is seen high at a clock edge. Each edge with both high moves exactly one symbol. The consumer may hold `sym_ready` low for any number of cycles and may raise it before valid appears. The control and status pins (`busy`, `done`, `cmd_err`) are plain levels or pulses with no handshake.

Top module: `auxreq_seq`

## Requirements
- R1: After reset, `busy`, `sym_valid`, `done` and `cmd_err` are low and the write-data FIFO is empty.
- R2: A register write to offset 0x100 while idle launches a frame. `busy` is high from the next cycle, and the first symbol offered is a start symbol. Symbol kind encoding: 1 = start, 0 = byte, 2 = stop.
- R3: A write burst (command word bit 12 = 0, bit 4 = 0) sends these symbols in order: start, the command byte taken from bits [11:4] of the command word, the device-address bytes most-significant first, a length byte equal to bits [3:0] zero-extended, then bits[3:0]+1 payload bytes, then stop. The command and address are captured when the frame launches.
- R4: Payload bytes are pushed with writes to offset 0x104 (data bits [7:0]) and leave the FIFO in push order. A push into a full FIFO is dropped.
- R5: A read burst (bit 4 = 1, bit 12 = 0) sends start, command, address, length, stop. It sends no payload and leaves the FIFO contents untouched.
- R6: With bit 12 set, the frame is start, command, address, stop, whatever the command code and length field hold (this includes the write-status poll). The FIFO is left untouched.
- R7: While `sym_valid` is high and `sym_ready` is low, `sym_valid`, `sym_kind` and `sym_byte` hold their values.
- R8: `done` is high for exactly the one cycle after the stop symbol is accepted, and `busy` is low in that cycle.
- R9: A command write while `busy` is high is ignored and sets `cmd_err`. The frame in flight is unchanged, including its address even if offset 0x108 is rewritten meanwhile.
- R10: A write burst whose length needs more bytes than the FIFO holds is rejected. No frame is sent, `cmd_err` is set, and the FIFO keeps its bytes.
- R11: `cmd_err` stays high once set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (12) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| sym_valid | output | 1 | A frame symbol is offered |
| sym_ready | input | 1 | Encoder accepts the symbol |
| sym_kind | output | 2 | 0 byte, 1 start, 2 stop |
| sym_byte | output | 8 | Byte value for byte symbols, zero otherwise |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the stop symbol is accepted |
| cmd_err | output | 1 | Sticky: a command was ignored or rejected |

## Verification
The bench sweeps every length field value for write bursts and read bursts under three ready patterns. A design with an off-by-one in the payload counter would send one byte too many or too few. A design that drains the FIFO on reads or on address-only frames would then send the wrong bytes in the write burst that follows. A 17th push into a full FIFO must be dropped; a FIFO that lost this rule would corrupt its oldest byte. An address rewrite and a second command are issued while a frame is stalled. A design that used the live register or accepted the second command would change the frame in flight. A write burst that asks for more bytes than the FIFO holds must leave those bytes in place; a design that started the frame anyway would stall or send a short payload. Done is timed against the accepted stop symbol, so a pulse one cycle late or two cycles long shows up.

// File: rtl/auxreq_pkg.sv
package auxreq_pkg;
  typedef enum logic [1:0] {
    SYM_BYTE  = 2'd0,
    SYM_START = 2'd1,
    SYM_STOP  = 2'd2
  } sym_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_CMD, ST_ADDR, ST_LEN, ST_DATA, ST_STOP
  } seq_st_e;

  // command word layout
  localparam int CMD_AONLY_BIT = 12;
  localparam int CMD_CODE_LSB  = 4;
  localparam int CMD_READ_BIT  = 4;
endpackage

// File: rtl/auxreq_fifo.sv
module auxreq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && (count != CW'(DEPTH));
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/auxreq_regs.sv
module auxreq_regs #(
  parameter int REG_AW     = 12,
  parameter int ADDR_BYTES = 1,
  parameter logic [REG_AW-1:0] OFS_CMD  = 'h100,
  parameter logic [REG_AW-1:0] OFS_PUSH = 'h104,
  parameter logic [REG_AW-1:0] OFS_DEV  = 'h108,
  localparam int DAW = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              cmd_stb,
  output logic [31:0]       cmd_word,
  output logic              push_stb,
  output logic [7:0]        push_byte,
  output logic [DAW-1:0]    dev_addr
);
  assign cmd_stb   = reg_wr && (reg_addr == OFS_CMD);
  assign cmd_word  = reg_wdata;
  assign push_stb  = reg_wr && (reg_addr == OFS_PUSH);
  assign push_byte = reg_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              dev_addr <= '0;
    else if (reg_wr && reg_addr == OFS_DEV)  dev_addr <= reg_wdata[DAW-1:0];
  end
endmodule

// File: rtl/auxreq_frame.sv
module auxreq_frame
  import auxreq_pkg::*;
#(
  parameter int ADDR_BYTES = 1,
  parameter int LEN_W      = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int DAW = 8 * ADDR_BYTES,
  localparam int AIW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int CW  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_stb,
  input  logic [31:0]    cmd_word,
  input  logic [DAW-1:0] dev_addr,
  input  logic [CW-1:0]  fifo_count,
  input  logic [7:0]     fifo_dout,
  output logic           fifo_pop,
  output logic           sym_valid,
  input  logic           sym_ready,
  output logic [1:0]     sym_kind,
  output logic [7:0]     sym_byte,
  output logic           busy,
  output logic           done,
  output logic           cmd_err
);
  seq_st_e          st;
  logic [7:0]       code_q;
  logic [DAW-1:0]   addr_q;
  logic [LEN_W-1:0] len_q, rem_q;
  logic             rd_q, aonly_q;
  logic [AIW-1:0]   aidx;

  logic             w_aonly, w_rd, w_enough, w_ok;
  logic [LEN_W-1:0] w_len;

  assign w_aonly  = cmd_word[CMD_AONLY_BIT];
  assign w_rd     = cmd_word[CMD_READ_BIT];
  assign w_len    = cmd_word[LEN_W-1:0];
  assign w_enough = int'(fifo_count) > int'(w_len);
  assign w_ok     = w_aonly || w_rd || w_enough;

  assign busy      = (st != ST_IDLE);
  assign sym_valid = busy;
  assign fifo_pop  = (st == ST_DATA) && sym_ready;

  always_comb begin
    sym_kind = SYM_BYTE;
    sym_byte = 8'h00;
    case (st)
      ST_START: sym_kind = SYM_START;
      ST_STOP:  sym_kind = SYM_STOP;
      ST_CMD:   sym_byte = code_q;
      ST_ADDR:  sym_byte = addr_q[(ADDR_BYTES - 1 - int'(aidx)) * 8 +: 8];
      ST_LEN:   sym_byte = 8'(len_q);
      ST_DATA:  sym_byte = fifo_dout;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      code_q  <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      rd_q    <= 1'b0;
      aonly_q <= 1'b0;
      aidx    <= '0;
      done    <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (cmd_stb && w_ok) begin
          code_q  <= cmd_word[CMD_CODE_LSB +: 8];
          addr_q  <= dev_addr;
          len_q   <= w_len;
          rd_q    <= w_rd;
          aonly_q <= w_aonly;
          aidx    <= '0;
          st      <= ST_START;
        end else if (cmd_stb) begin
          cmd_err <= 1'b1;
        end
      end else begin
        if (cmd_stb) cmd_err <= 1'b1;
        if (sym_ready) begin
          case (st)
            ST_START: st <= ST_CMD;
            ST_CMD:   st <= ST_ADDR;
            ST_ADDR:
              if (aidx == AIW'(ADDR_BYTES - 1)) st <= aonly_q ? ST_STOP : ST_LEN;
              else                              aidx <= aidx + 1'b1;
            ST_LEN: begin
              rem_q <= len_q;
              st    <= rd_q ? ST_STOP : ST_DATA;
            end
            ST_DATA:
              if (rem_q == '0) st <= ST_STOP;
              else             rem_q <= rem_q - 1'b1;
            ST_STOP: begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/auxreq_seq.sv
module auxreq_seq #(
  parameter int REG_AW     = 12,
  parameter int ADDR_BYTES = 1,
  parameter int LEN_W      = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int DAW = 8 * ADDR_BYTES,
  localparam int CW  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [1:0]        sym_kind,
  output logic [7:0]        sym_byte,
  output logic              busy,
  output logic              done,
  output logic              cmd_err
);
  logic           cmd_stb, push_stb, fifo_pop;
  logic [31:0]    cmd_word;
  logic [7:0]     push_byte, fifo_dout;
  logic [DAW-1:0] dev_addr;
  logic [CW-1:0]  fifo_cnt;

  auxreq_regs #(.REG_AW(REG_AW), .ADDR_BYTES(ADDR_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cmd_stb(cmd_stb), .cmd_word(cmd_word),
    .push_stb(push_stb), .push_byte(push_byte), .dev_addr(dev_addr)
  );

  auxreq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_stb), .din(push_byte),
    .pop(fifo_pop), .dout(fifo_dout), .count(fifo_cnt)
  );

  auxreq_frame #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)) u_frame (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_word(cmd_word),
    .dev_addr(dev_addr), .fifo_count(fifo_cnt), .fifo_dout(fifo_dout),
    .fifo_pop(fifo_pop), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_kind(sym_kind), .sym_byte(sym_byte), .busy(busy), .done(done),
    .cmd_err(cmd_err)
  );
endmodule

// File: rtl/auxreq_seq_chk.sv
module auxreq_seq_chk #(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_valid,
  input logic          sym_ready,
  input logic [1:0]    sym_kind,
  input logic [7:0]    sym_byte,
  input logic          busy,
  input logic          done,
  input logic          cmd_err,
  input logic [CW-1:0] fifo_cnt
);
  // R7: offered symbol held under back-pressure
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !sym_ready |=> sym_valid && $stable(sym_kind) && $stable(sym_byte));

  // R8: done follows an accepted stop symbol
  a_r8_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(sym_valid && sym_ready && sym_kind == 2'd2));

  // R8: done is a single-cycle pulse with busy low
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  // R11: error flag sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  // R2: symbols only while a frame is in progress
  a_r2_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> busy);

  // R4: FIFO occupancy bounded
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= FIFO_DEPTH);
endmodule

bind auxreq_seq auxreq_seq_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
  .sym_kind(sym_kind), .sym_byte(sym_byte), .busy(busy), .done(done),
  .cmd_err(cmd_err), .fifo_cnt(fifo_cnt)
);

// File: tb/auxreq_seq_test.sv
module auxreq_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXSYM = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        sym_valid, sym_ready, busy, done, cmd_err;
  logic [1:0]  sym_kind;
  logic [7:0]  sym_byte;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_stop = -10, done_cnt = 0, rmode = 0;
  logic prev_done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int cap_n = 0, exp_n = 0;
  logic [1:0] cap_k [MAXSYM];
  logic [7:0] cap_b [MAXSYM];
  logic [1:0] exp_k [MAXSYM];
  logic [7:0] exp_b [MAXSYM];

  auxreq_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_kind(sym_kind), .sym_byte(sym_byte), .busy(busy), .done(done),
    .cmd_err(cmd_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: drives ready and records handshakes at the falling edge
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      0: sym_ready = 1'b1;
      1: sym_ready = lfsr[0];
      2: sym_ready = (cyc % 4 == 0);
      default: sym_ready = 1'b0;
    endcase
    if (rst_n && sym_valid && sym_ready && cap_n < MAXSYM) begin
      cap_k[cap_n] = sym_kind;
      cap_b[cap_n] = sym_byte;
      cap_n++;
      if (sym_kind == 2'd2) last_stop = cyc;
    end
    if (rst_n && done) begin
      done_cnt++;
      chk(last_stop == cyc - 1, "R8 done timing", cyc - last_stop, 1);
      chk(!busy, "R8 busy low with done", int'(busy), 0);
      chk(!prev_done, "R8 done one cycle", int'(prev_done), 0);
    end
    prev_done = done;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] cw(input bit aonly, input logic [7:0] code, input int len);
    return {19'b0, aonly, code, 4'(len)};
  endfunction

  task automatic exp_add(input logic [1:0] k, input logic [7:0] b);
    exp_k[exp_n] = k; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic exp_hdr(input logic [7:0] code, input logic [7:0] addr);
    exp_n = 0;
    exp_add(2'd1, 8'h00);
    exp_add(2'd0, code);
    exp_add(2'd0, addr);
  endtask

  task automatic wait_done(input string req);
    int d0 = done_cnt;
    int t = 0;
    while (done_cnt == d0 && t < 3000) begin @(negedge clk); t++; end
    chk(done_cnt != d0, req, 0, 1);
    @(negedge clk);
  endtask

  task automatic cmp(input string req);
    int bad = -1;
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (bad < 0 && (cap_k[i] != exp_k[i] || cap_b[i] != exp_b[i])) bad = i;
    if (cap_n != exp_n) chk(0, {req, " symbol count"}, cap_n, exp_n);
    else if (bad >= 0) chk(0, {req, " symbol"}, {22'd0, cap_k[bad], cap_b[bad]},
                           {22'd0, exp_k[bad], exp_b[bad]});
    else chk(1, req, 0, 0);
  endtask

  task automatic launch(input logic [31:0] w, input string req);
    cap_n = 0;
    wr(12'h100, w);
    chk(busy == 1'b1, "R2 busy after launch", int'(busy), 1);
    wait_done(req);
    cmp(req);
  endtask

  initial begin
    sym_ready = 1'b1;
    do_reset();
    // R1 reset state
    chk(!busy && !sym_valid && !done && !cmd_err, "R1 reset outputs",
        {busy, sym_valid, done, cmd_err}, 0);

    // R1: FIFO empty after reset -> write burst len 0 must be rejected later; check via read first
    // R3/R4/R2: write burst sweep over every length and three ready patterns
    for (int len = 0; len < 16; len++) begin
      rmode = len % 3;
      wr(12'h108, 32'(8'hA0 + len));
      for (int i = 0; i <= len; i++) wr(12'h104, 32'((len * 7 + i * 13 + 1) & 255));
      exp_hdr(8'h40, 8'(8'hA0 + len));
      exp_add(2'd0, 8'(len));
      for (int i = 0; i <= len; i++) exp_add(2'd0, 8'((len * 7 + i * 13 + 1) & 255));
      exp_add(2'd2, 8'h00);
      launch(cw(0, 8'h40, len), "R3 write burst frame");
    end

    // R5: read bursts leave three preloaded bytes in place
    for (int i = 0; i < 3; i++) wr(12'h104, 32'(8'hC0 + i));
    for (int len = 0; len < 16; len++) begin
      rmode = (len + 1) % 3;
      wr(12'h108, 32'(8'h30 + len));
      exp_hdr(8'h51, 8'(8'h30 + len));
      exp_add(2'd0, 8'(len));
      exp_add(2'd2, 8'h00);
      launch(cw(0, 8'h51, len), "R5 read burst frame");
    end

    // R6: address-only frames for write, status poll and read codes
    rmode = 1;
    wr(12'h108, 32'h5A);
    exp_hdr(8'h40, 8'h5A); exp_add(2'd2, 8'h00);
    launch(cw(1, 8'h40, 9), "R6 address-only write");
    exp_hdr(8'h42, 8'h5A); exp_add(2'd2, 8'h00);
    launch(cw(1, 8'h42, 15), "R6 address-only status poll");
    exp_hdr(8'h51, 8'h5A); exp_add(2'd2, 8'h00);
    launch(cw(1, 8'h51, 0), "R6 address-only read");

    // R5/R6: the three bytes are still first in the FIFO
    exp_hdr(8'h40, 8'h5A); exp_add(2'd0, 8'd2);
    for (int i = 0; i < 3; i++) exp_add(2'd0, 8'(8'hC0 + i));
    exp_add(2'd2, 8'h00);
    launch(cw(0, 8'h40, 2), "R5 R6 FIFO untouched");
    chk(cmd_err == 1'b0, "R11 no error yet", int'(cmd_err), 0);

    // R4: 17 pushes, the last dropped
    rmode = 2;
    for (int i = 0; i < 17; i++) wr(12'h104, 32'(100 + i));
    exp_hdr(8'h40, 8'h5A); exp_add(2'd0, 8'd15);
    for (int i = 0; i < 16; i++) exp_add(2'd0, 8'(100 + i));
    exp_add(2'd2, 8'h00);
    launch(cw(0, 8'h40, 15), "R4 full FIFO drops push");

    // R9: command and address write while stalled are ignored
    for (int i = 0; i < 4; i++) wr(12'h104, 32'(8'hE0 + i));
    wr(12'h108, 32'h11);
    rmode = 3;
    cap_n = 0;
    wr(12'h100, cw(0, 8'h40, 3));
    repeat (3) @(negedge clk);
    wr(12'h108, 32'h99);
    wr(12'h100, cw(0, 8'h51, 1));
    chk(cmd_err == 1'b1, "R9 error on busy command", int'(cmd_err), 1);
    chk(sym_kind == 2'd1 && sym_valid, "R7 start held while stalled", int'(sym_kind), 1);
    rmode = 0;
    wait_done("R9 frame completes");
    repeat (20) @(negedge clk);
    exp_hdr(8'h40, 8'h11); exp_add(2'd0, 8'd3);
    for (int i = 0; i < 4; i++) exp_add(2'd0, 8'(8'hE0 + i));
    exp_add(2'd2, 8'h00);
    cmp("R9 frame unchanged, no second frame");
    chk(cmd_err == 1'b1, "R11 error stays set", int'(cmd_err), 1);

    // R10: short FIFO rejects a write burst
    do_reset();
    chk(cmd_err == 1'b0, "R11 reset clears error", int'(cmd_err), 0);
    wr(12'h104, 32'h77); wr(12'h104, 32'h78);
    wr(12'h108, 32'h2B);
    cap_n = 0;
    wr(12'h100, cw(0, 8'h40, 5));
    repeat (20) @(negedge clk);
    chk(cap_n == 0 && !busy, "R10 no frame on short FIFO", cap_n, 0);
    chk(cmd_err == 1'b1, "R10 error on short FIFO", int'(cmd_err), 1);
    exp_hdr(8'h40, 8'h2B); exp_add(2'd0, 8'd1);
    exp_add(2'd0, 8'h77); exp_add(2'd0, 8'h78); exp_add(2'd2, 8'h00);
    launch(cw(0, 8'h40, 1), "R10 FIFO kept after reject");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule